// File: doc/BRIEF.md
# Fault-Injectable AES-128 Final Round

This block evaluates the closing round of AES-128 on one 128-bit state and one 128-bit round key. A 3-bit fault selector can make the round drop or misuse one of its transformations: leave out the byte substitution, replace it with the inverse substitution, leave out the row rotation, add a column mix, or leave out the key addition. A bench or a fault-analysis setup can then obtain both the correct and the faulty ciphertext from the same state and key.

A 16-bit byte mask limits the fault to part of the state. A byte, row or column outside the mask takes the fault-free result. State and key bytes are numbered column-major: byte i sits in row i mod 4 and column i div 4. Byte 0 is the most significant byte, bits [127:120]. Mask bit i (bit 0 is the least significant) covers byte i.

Inputs arrive on a valid/ready port. The output has no back-pressure: every accepted input produces one output strobe exactly one cycle later. For that reason `in_ready` stays high from the second cycle after reset onwards, and the producer may present a new input on every cycle.

Top module: `aes_fi_last_round`

## Requirements
- R1: With fault code 0, `out_data` equals ShiftRows(SubBytes(S)) XOR K, with no MixColumns. Under the column-major byte numbering, output byte c*4+r is taken from the substituted input byte ((c+r) mod 4)*4+r. An all-zero state with an all-zero key gives 0x63 in every byte.
- R2: Fault code 1 skips the substitution for every input byte i whose mask bit i is 1. That byte passes unchanged into the row rotation. An all-zero state with an all-zero key and a full mask gives all zeros.
- R3: Fault code 2 applies the inverse S-box, not the forward S-box, to every input byte i whose mask bit i is 1. An all-zero state with an all-zero key and a full mask gives 0x52 in every byte.
- R4: Fault code 3 leaves row r unrotated when any of mask bits r, 4+r, 8+r and 12+r is 1. Row 0 comes out the same as with fault code 0, whatever the mask.
- R5: Fault code 4 applies the standard MixColumns matrix (2 3 1 1, circulant) to column c of the rotated state when any of mask bits 4c to 4c+3 is 1, before the key is added.
- R6: Fault code 5 leaves out the key addition for every output byte i whose mask bit i is 1.
- R7: Fault codes 6 and 7 act as code 0. An all-zero mask gives the fault-free result under every fault code.
- R8: While reset is high, `in_ready` is 0. From the second cycle after reset is released it is 1, and once high it stays high until the next reset. An input is accepted on a rising edge at which `in_valid` and `in_ready` are both 1.
- R9: `out_valid` is high for exactly the one cycle after each accepted input, and `out_data` updates in that cycle. At all other times `out_valid` is low and `out_data` keeps its last value.
- R10: While reset is held, `out_valid` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_state | input | 128 | State entering the final round, byte 0 in the most significant bits |
| in_key | input | 128 | Final round key, same byte order as the state |
| in_fault | input | 3 | Fault selector, codes 0 to 7 |
| in_mask | input | 16 | Byte mask: bit i covers byte i |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | 128 | Registered round output |

## Verification
Every ciphertext is due on the clock edge that follows the accepting edge. The bench raises `in_valid` on a falling edge and drops it on the next falling edge, then samples `out_valid` and `out_data` on that same falling edge, half a period after the result was registered. On the falling edge one cycle later, it checks that `out_valid` has dropped and that `out_data` has not changed. `in_ready` is checked while reset is held, and again two cycles after reset is released. Expected ciphertexts come from a bench model. That model builds its S-box from a generator-3 log table, and a few fixed known bytes (0x63, 0x52, 0xED) anchor it.

// File: rtl/aes_fi_pkg.sv
package aes_fi_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_ROWS  = 4;
  localparam int unsigned N_COLS  = 4;
  localparam int unsigned N_BYTES = N_ROWS * N_COLS;
  localparam int unsigned STATE_W = N_BYTES * BYTE_W;
  localparam int unsigned FAULT_W = 3;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE      = 3'd0,
    FLT_NO_SUB    = 3'd1,
    FLT_INV_SUB   = 3'd2,
    FLT_NO_SHIFT  = 3'd3,
    FLT_ADD_MIX   = 3'd4,
    FLT_NO_KEY    = 3'd5
  } fault_code_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    res = 8'h01;
    pw  = a;
    for (int k = 0; k < 8; k++) begin
      if (k != 0) res = gf_mul(res, pw);
      pw = gf_mul(pw, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int unsigned n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] t;
    t = gf_inv(a);
    return t ^ rotl8(t, 1) ^ rotl8(t, 2) ^ rotl8(t, 3) ^ rotl8(t, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] a);
    logic [7:0] t;
    t = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
    return gf_inv(t);
  endfunction

endpackage

// File: rtl/aes_fi_sbox_lane.sv
module aes_fi_sbox_lane
  import aes_fi_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  input  logic              use_inv,
  input  logic              bypass,
  output logic [BYTE_W-1:0] dout
);

  logic [BYTE_W-1:0] fwd_b;
  logic [BYTE_W-1:0] inv_b;

  always_comb begin
    fwd_b = sbox_fwd(din);
    inv_b = sbox_inv(din);
    if (bypass)       dout = din;
    else if (use_inv) dout = inv_b;
    else              dout = fwd_b;
  end

endmodule

// File: rtl/aes_fi_subbytes.sv
module aes_fi_subbytes
  import aes_fi_pkg::*;
#(
  parameter int unsigned NB = N_BYTES,
  localparam int unsigned W = NB * BYTE_W
)(
  input  logic [W-1:0]  din,
  input  logic [NB-1:0] inv_en,
  input  logic [NB-1:0] byp_en,
  output logic [W-1:0]  dout
);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int unsigned HI = W - 1 - i * BYTE_W;
    aes_fi_sbox_lane u_lane (
      .din     (din[HI -: BYTE_W]),
      .use_inv (inv_en[i]),
      .bypass  (byp_en[i]),
      .dout    (dout[HI -: BYTE_W])
    );
  end

endmodule

// File: rtl/aes_fi_shiftrows.sv
module aes_fi_shiftrows
  import aes_fi_pkg::*;
(
  input  logic [STATE_W-1:0] din,
  input  logic [N_ROWS-1:0]  row_hold,
  output logic [STATE_W-1:0] dout
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
      localparam int unsigned DST = c * N_ROWS + r;
      localparam int unsigned SRC = ((c + r) % N_COLS) * N_ROWS + r;
      localparam int unsigned DHI = STATE_W - 1 - DST * BYTE_W;
      localparam int unsigned SHI = STATE_W - 1 - SRC * BYTE_W;
      assign dout[DHI -: BYTE_W] = row_hold[r] ? din[DHI -: BYTE_W] : din[SHI -: BYTE_W];
    end
  end

endmodule

// File: rtl/aes_fi_mixcols.sv
module aes_fi_mixcols
  import aes_fi_pkg::*;
(
  input  logic [STATE_W-1:0] din,
  input  logic [N_COLS-1:0]  col_en,
  output logic [STATE_W-1:0] dout
);

  localparam int unsigned COL_W = N_ROWS * BYTE_W;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    localparam int unsigned HI = STATE_W - 1 - c * COL_W;
    logic [BYTE_W-1:0] a0, a1, a2, a3;
    logic [BYTE_W-1:0] m0, m1, m2, m3;
    always_comb begin
      {a0, a1, a2, a3} = din[HI -: COL_W];
      m0 = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
      m1 = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
      m2 = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
      m3 = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
    end
    assign dout[HI -: COL_W] = col_en[c] ? {m0, m1, m2, m3} : din[HI -: COL_W];
  end

endmodule

// File: rtl/aes_fi_last_round.sv
module aes_fi_last_round
  import aes_fi_pkg::*;
#(
  parameter int unsigned MASK_W = N_BYTES,
  parameter int unsigned DATA_W = STATE_W
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_state,
  input  logic [DATA_W-1:0]   in_key,
  input  logic [FAULT_W-1:0]  in_fault,
  input  logic [MASK_W-1:0]   in_mask,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data
);

  logic [MASK_W-1:0]  sub_byp;
  logic [MASK_W-1:0]  sub_inv;
  logic [N_ROWS-1:0]  row_hold;
  logic [N_COLS-1:0]  col_mix;
  logic [MASK_W-1:0]  key_drop;
  logic [DATA_W-1:0]  sub_q;
  logic [DATA_W-1:0]  shf_q;
  logic [DATA_W-1:0]  mix_q;
  logic [DATA_W-1:0]  ct;
  logic               accept;

  // fault decode: codes 6 and 7 fall into the default branch
  always_comb begin
    sub_byp  = '0;
    sub_inv  = '0;
    row_hold = '0;
    col_mix  = '0;
    key_drop = '0;
    case (in_fault)
      FLT_NO_SUB:   sub_byp  = in_mask;
      FLT_INV_SUB:  sub_inv  = in_mask;
      FLT_NO_SHIFT: begin
        for (int r = 0; r < N_ROWS; r++)
          for (int c = 0; c < N_COLS; c++)
            row_hold[r] = row_hold[r] | in_mask[c * N_ROWS + r];
      end
      FLT_ADD_MIX: begin
        for (int c = 0; c < N_COLS; c++)
          for (int r = 0; r < N_ROWS; r++)
            col_mix[c] = col_mix[c] | in_mask[c * N_ROWS + r];
      end
      FLT_NO_KEY:   key_drop = in_mask;
      default: ;
    endcase
  end

  aes_fi_subbytes #(.NB(N_BYTES)) u_sub (
    .din    (in_state),
    .inv_en (sub_inv),
    .byp_en (sub_byp),
    .dout   (sub_q)
  );

  aes_fi_shiftrows u_shf (
    .din      (sub_q),
    .row_hold (row_hold),
    .dout     (shf_q)
  );

  aes_fi_mixcols u_mix (
    .din    (shf_q),
    .col_en (col_mix),
    .dout   (mix_q)
  );

  for (genvar i = 0; i < N_BYTES; i++) begin : g_key
    localparam int unsigned HI = DATA_W - 1 - i * BYTE_W;
    assign ct[HI -: BYTE_W] = mix_q[HI -: BYTE_W] ^ (key_drop[i] ? '0 : in_key[HI -: BYTE_W]);
  end

  assign accept = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      if (accept) out_data <= ct;
    end
  end

endmodule

// File: rtl/aes_fi_last_round_chk.sv
module aes_fi_last_round_chk #(
  parameter int unsigned DATA_W = 128
)(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  assert_valid_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_no_valid_without_accept_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !out_valid);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(out_data));

  assert_ready_stays_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

endmodule

bind aes_fi_last_round aes_fi_last_round_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_aes_fi_last_round.sv
module test_aes_fi_last_round;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic [2:0]   in_fault = '0;
  logic [15:0]  in_mask = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] fwd_t [256];
  logic [7:0] inv_t [256];

  always #5 clk = ~clk;

  aes_fi_last_round i_aes_fi_last_round (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_state  (in_state),
    .in_key    (in_key),
    .in_fault  (in_fault),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box tables from a generator-3 log table
  task automatic build_tables();
    logic [7:0] ex [255];
    int lg [256];
    logic [7:0] p;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = p;
      lg[p] = i;
      p = p ^ xt(p);
    end
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv;
      logic [7:0] s;
      iv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      for (int b = 0; b < 8; b++)
        s[b] = iv[b] ^ iv[(b + 4) % 8] ^ iv[(b + 5) % 8] ^ iv[(b + 6) % 8]
             ^ iv[(b + 7) % 8] ^ ((8'h63 >> b) & 8'h01) != 0;
      fwd_t[x] = s;
    end
    for (int x = 0; x < 256; x++) inv_t[fwd_t[x]] = x[7:0];
  endtask

  function automatic logic [127:0] model(input logic [127:0] st, input logic [127:0] k,
                                         input logic [2:0] md, input logic [15:0] mk);
    logic [7:0] a [16];
    logic [7:0] sb [16];
    logic [7:0] sr [16];
    logic [7:0] mx [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      a[i] = st[127 - 8 * i -: 8];
      if (md == 3'd1 && mk[i])      sb[i] = a[i];
      else if (md == 3'd2 && mk[i]) sb[i] = inv_t[a[i]];
      else                          sb[i] = fwd_t[a[i]];
    end
    for (int r = 0; r < 4; r++) begin
      bit hold;
      hold = (md == 3'd3) && (mk[r] | mk[4 + r] | mk[8 + r] | mk[12 + r]);
      for (int c = 0; c < 4; c++)
        sr[c * 4 + r] = hold ? sb[c * 4 + r] : sb[((c + r) % 4) * 4 + r];
    end
    for (int c = 0; c < 4; c++) begin
      logic [7:0] b0, b1, b2, b3;
      b0 = sr[4 * c]; b1 = sr[4 * c + 1]; b2 = sr[4 * c + 2]; b3 = sr[4 * c + 3];
      if (md == 3'd4 && (mk[4 * c +: 4] != 4'h0)) begin
        mx[4 * c]     = xt(b0) ^ xt(b1) ^ b1 ^ b2 ^ b3;
        mx[4 * c + 1] = b0 ^ xt(b1) ^ xt(b2) ^ b2 ^ b3;
        mx[4 * c + 2] = b0 ^ b1 ^ xt(b2) ^ xt(b3) ^ b3;
        mx[4 * c + 3] = xt(b0) ^ b0 ^ b1 ^ b2 ^ xt(b3);
      end else begin
        mx[4 * c] = b0; mx[4 * c + 1] = b1; mx[4 * c + 2] = b2; mx[4 * c + 3] = b3;
      end
    end
    for (int i = 0; i < 16; i++)
      o[127 - 8 * i -: 8] = mx[i] ^ ((md == 3'd5 && mk[i]) ? 8'h00 : k[127 - 8 * i -: 8]);
    return o;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one beat: accept on a rising edge, result sampled on the next falling edge
  task automatic send(input string req, input logic [127:0] st, input logic [127:0] k,
                      input logic [2:0] md, input logic [15:0] mk, output logic [127:0] got);
    @(negedge clk);
    in_valid = 1'b1; in_state = st; in_key = k; in_fault = md; in_mask = mk;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " strobe"}, {127'b0, out_valid}, 128'd1);
    chk(req, out_data, model(st, k, md, mk));
    got = out_data;
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk("R10 out_valid in reset", {127'b0, out_valid}, 128'd0);
    chk("R10 out_data in reset", out_data, 128'd0);
    chk("R8 in_ready in reset", {127'b0, in_ready}, 128'd0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 in_ready after reset", {127'b0, in_ready}, 128'd1);
  endtask

  task automatic t_anchors();
    logic [127:0] g;
    chk("R1 sbox table 0x53", {120'b0, fwd_t[8'h53]}, {120'b0, 8'hed});
    send("R1 zero state", '0, '0, 3'd0, 16'h0000, g);
    chk("R1 zero constant", g, {16{8'h63}});
    send("R2 zero state", '0, '0, 3'd1, 16'hffff, g);
    chk("R2 zero constant", g, 128'd0);
    send("R3 zero state", '0, '0, 3'd2, 16'hffff, g);
    chk("R3 zero constant", g, {16{8'h52}});
  endtask

  task automatic t_normal();
    logic [127:0] g;
    send("R1 ramp", 128'h000102030405060708090a0b0c0d0e0f, 128'h0f0e0d0c0b0a09080706050403020100,
         3'd0, 16'hffff, g);
    for (int n = 0; n < 6; n++) send("R1 random", rnd128(), rnd128(), 3'd0, $urandom, g);
  endtask

  task automatic t_sub_faults();
    logic [127:0] g;
    logic [127:0] s;
    logic [127:0] k;
    s = rnd128(); k = rnd128();
    send("R2 full mask", s, k, 3'd1, 16'hffff, g);
    send("R2 single byte", s, k, 3'd1, 16'h0020, g);
    send("R3 full mask", s, k, 3'd2, 16'hffff, g);
    send("R3 subset", s, k, 3'd2, 16'h8181, g);
  endtask

  task automatic t_shift_fault();
    logic [127:0] s;
    logic [127:0] k;
    logic [127:0] g0;
    logic [127:0] g1;
    logic [127:0] rowm;
    s = 128'h00112233445566778899aabbccddeeff; k = rnd128();
    send("R1 reference", s, k, 3'd0, 16'hffff, g0);
    send("R4 full mask", s, k, 3'd3, 16'hffff, g1);
    rowm = {4{32'hff000000}};
    chk("R4 row 0 unchanged", g1 & rowm, g0 & rowm);
    send("R4 row 2 only", s, k, 3'd3, 16'h0004, g1);
    send("R4 row 0 only", s, k, 3'd3, 16'h0001, g1);
    chk("R4 row 0 mask no effect", g1, g0);
  endtask

  task automatic t_mix_key();
    logic [127:0] g;
    logic [127:0] s;
    logic [127:0] k;
    logic [127:0] g0;
    s = rnd128(); k = rnd128();
    send("R5 full mask", s, k, 3'd4, 16'hffff, g);
    send("R5 column 1", s, k, 3'd4, 16'h00f0, g);
    send("R5 column 3 one bit", s, k, 3'd4, 16'h4000, g);
    send("R1 reference", s, k, 3'd0, 16'h0000, g0);
    send("R6 full mask", s, k, 3'd5, 16'hffff, g);
    chk("R6 key removed", g ^ k, g0);
    send("R6 subset", s, k, 3'd5, 16'h0f0f, g);
  endtask

  task automatic t_unused();
    logic [127:0] g;
    logic [127:0] g0;
    logic [127:0] s;
    logic [127:0] k;
    s = rnd128(); k = rnd128();
    send("R7 reference", s, k, 3'd0, 16'hffff, g0);
    send("R7 code 6", s, k, 3'd6, 16'hffff, g);
    chk("R7 code 6 equals none", g, g0);
    send("R7 code 7", s, k, 3'd7, 16'hffff, g);
    chk("R7 code 7 equals none", g, g0);
    for (int m = 1; m < 6; m++) begin
      send("R7 zero mask", s, k, m[2:0], 16'h0000, g);
      chk("R7 zero mask equals none", g, g0);
    end
  endtask

  task automatic t_hold();
    logic [127:0] g;
    send("R9 beat", rnd128(), rnd128(), 3'd0, 16'h0000, g);
    @(negedge clk);
    chk("R9 strobe drops", {127'b0, out_valid}, 128'd0);
    chk("R9 data held", out_data, g);
    in_state = rnd128(); in_key = rnd128();
    @(negedge clk); @(negedge clk);
    chk("R9 idle inputs ignored", out_data, g);
    // two back-to-back beats give two strobes
    @(negedge clk);
    in_valid = 1'b1; in_state = 128'h1; in_key = 128'h2; in_fault = 3'd0; in_mask = 16'h0;
    @(negedge clk);
    chk("R9 first of pair", out_data, model(128'h1, 128'h2, 3'd0, 16'h0));
    in_state = 128'h3; in_key = 128'h4;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second strobe", {127'b0, out_valid}, 128'd1);
    chk("R9 second of pair", out_data, model(128'h3, 128'h4, 3'd0, 16'h0));
    @(negedge clk);
    chk("R9 pair ends", {127'b0, out_valid}, 128'd0);
  endtask

  initial begin
    build_tables();
    t_reset();
    t_anchors();
    t_normal();
    t_sub_faults();
    t_shift_fault();
    t_mix_key();
    t_unused();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule